// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block gathers event pulses from four functional areas of a link-layer device: link/PHY control, isochronous receive, isochronous transmit and the asynchronous transceiver. Each area has a latching status register and a matching per-bit enable register. An event pulse sets its status bit, and the bit stays set until the host acknowledges it by writing a one to that position.

Above the area registers sits a read-only summary nibble with one bit per area. Each summary bit is the OR of that area's status bits masked by their enables. The summary does not latch. It drops by itself once every enabled cause in its area has been acknowledged. The OR of the four summary bits drives a single active-low interrupt line to the host.

A plain synchronous register port gives reads and writes at fixed byte addresses. A read is requested for one cycle, and its data comes back one cycle later, marked by a valid strobe. There is no back-pressure: every request is accepted in the cycle it is presented, and the read result is held for exactly one cycle.

Top module: `irq_hier_agg`

## Requirements
- R1: After reset, all status and enable bits are zero, `irq_summary` is 0 and `irq_n` is 1.
- R2: A one on an event input sets the matching status bit at the next clock edge. The bit stays set after the pulse ends, whatever the state of its enable bit.
- R3: A write to a status register clears every bit written as 1 and leaves every bit written as 0 unchanged. The status addresses are 0x008 (link/PHY), 0x04C (receive), 0x02C (transmit) and 0x0A0 (asynchronous).
- R4: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Each enable register sits at its status address plus 4 (0x00C, 0x050, 0x030, 0x0A4). It is fully readable and writable, and it changes only when written.
- R6: Summary bit i is the OR of (status AND enable) of area i. Bit 0 is link/PHY, bit 1 is receive, bit 2 is transmit and bit 3 is asynchronous. The summary appears on `irq_summary` and in bits 3:0 of address 0x018, whose upper bits read as zero.
- R7: `irq_n` is 0 exactly when at least one summary bit is 1.
- R8: Writes to 0x018 have no effect. A summary bit returns to 0 by itself once the enabled set bits of its area have been cleared.
- R9: When `bus_rd_en` is 1 at a clock edge, `bus_rvalid` is 1 for the following cycle and `bus_rdata` holds the register value from before that edge. Unmapped addresses read as zero, and `bus_rvalid` is 0 after a cycle with no read request.
- R10: Register bits at positions STAT_W and above read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_link | input | STAT_W | Link/PHY event pulses |
| ev_rx | input | STAT_W | Isochronous receive event pulses |
| ev_tx | input | STAT_W | Isochronous transmit event pulses |
| ev_async | input | STAT_W | Asynchronous transceiver event pulses |
| bus_wr_en | input | 1 | Write request |
| bus_rd_en | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after the request |
| bus_rvalid | output | 1 | Read data strobe |
| irq_summary | output | 4 | Per-area summary nibble |
| irq_n | output | 1 | Active-low interrupt to the host |

## Verification
The bench builds the block with STAT_W = 4, ADDR_W = 12 and DATA_W = 32. At that width every combination of enable mask and event pattern can be swept in every area, with a partial acknowledge and a full acknowledge after each pulse. The narrow width also puts the zero-reading upper register bits in reach of a single all-ones write. Directed cases then cover an event and a clear hitting the same cycle, writes to the summary address, unmapped reads, and summaries from several areas active at once.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_AREAS = 4;

  typedef enum logic [1:0] {
    AREA_LINK  = 2'd0,
    AREA_RX    = 2'd1,
    AREA_TX    = 2'd2,
    AREA_ASYNC = 2'd3
  } area_e;

  localparam logic [11:0] GLOB_OFFSET = 12'h018;
  localparam logic [11:0] ENABLE_GAP  = 12'h004;

  // byte offset of an area's status register, indexed by summary bit
  function automatic logic [11:0] status_offset(input int unsigned area);
    case (area)
      32'd0:   return 12'h008;
      32'd1:   return 12'h04C;
      32'd2:   return 12'h02C;
      default: return 12'h0A0;
    endcase
  endfunction
endpackage

// File: rtl/irq_area_reg.sv
module irq_area_reg #(
  parameter int STAT_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev,
  input  logic              stat_we,
  input  logic              en_we,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] stat,
  output logic [STAT_W-1:0] en,
  output logic              pending
);
  logic [STAT_W-1:0] clr_mask;
  logic [STAT_W-1:0] stat_nxt;

  always_comb begin
    clr_mask = stat_we ? wdata : '0;
    // a fresh event outranks an acknowledge in the same cycle
    stat_nxt = (stat & ~clr_mask) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      stat <= stat_nxt;
      if (en_we) en <= wdata;
    end
  end

  assign pending = |(stat & en);

  // R2, R4: every pulsed bit is set one cycle later
  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(ev)) == $past(ev)));

  // R3: bits not written with 1 never drop
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat) & ~$past(clr_mask) & ~stat) == '0));

  // R3: acknowledged bits without a new event are cleared
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(clr_mask) & ~$past(ev)) == '0));

  // R5: enable changes only when written
  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en));
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  output logic [NUM_AREAS-1:0] stat_hit,
  output logic [NUM_AREAS-1:0] en_hit,
  output logic                 glob_hit,
  output logic [NUM_AREAS-1:0] stat_we,
  output logic [NUM_AREAS-1:0] en_we
);
  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    localparam logic [11:0] SOFF = status_offset(g);
    localparam logic [11:0] EOFF = SOFF + ENABLE_GAP;
    assign stat_hit[g] = (addr == ADDR_W'(SOFF));
    assign en_hit[g]   = (addr == ADDR_W'(EOFF));
    assign stat_we[g]  = wr_en & stat_hit[g];
    assign en_we[g]    = wr_en & en_hit[g];
  end

  // the summary register accepts no write strobe at all (R8)
  assign glob_hit = (addr == ADDR_W'(GLOB_OFFSET));

  // R9: at most one register is selected by any address
  p_onehot_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_hit, en_hit, glob_hit}));

  // R8: a write to the summary address strobes no register
  p_glob_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && glob_hit) |-> (stat_we == '0 && en_we == '0));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_agg_pkg::*;
#(
  parameter int STAT_W = 19,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_en,
  input  logic [NUM_AREAS-1:0]             stat_hit,
  input  logic [NUM_AREAS-1:0]             en_hit,
  input  logic                             glob_hit,
  input  logic [NUM_AREAS-1:0][STAT_W-1:0] stat_all,
  input  logic [NUM_AREAS-1:0][STAT_W-1:0] en_all,
  input  logic [NUM_AREAS-1:0]             summary,
  output logic [DATA_W-1:0]                rdata,
  output logic                             rvalid
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_AREAS; i++) begin
      if (stat_hit[i]) rd_mux = DATA_W'(stat_all[i]);
      if (en_hit[i])   rd_mux = DATA_W'(en_all[i]);
    end
    if (glob_hit) rd_mux = DATA_W'(summary);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      rdata  <= rd_en ? rd_mux : '0;
    end
  end

  // R9: each request yields exactly one valid cycle
  p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  p_no_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

  // R6: summary word has nothing above the nibble
  p_glob_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && glob_hit) |=> (rdata[DATA_W-1:NUM_AREAS] == '0));
endmodule

// File: rtl/irq_hier_agg.sv
module irq_hier_agg
  import irq_agg_pkg::*;
#(
  parameter int STAT_W = 19,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev_link,
  input  logic [STAT_W-1:0] ev_rx,
  input  logic [STAT_W-1:0] ev_tx,
  input  logic [STAT_W-1:0] ev_async,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [3:0]        irq_summary,
  output logic              irq_n
);
  logic [NUM_AREAS-1:0][STAT_W-1:0] ev_all;
  logic [NUM_AREAS-1:0][STAT_W-1:0] stat_all;
  logic [NUM_AREAS-1:0][STAT_W-1:0] en_all;
  logic [NUM_AREAS-1:0]             pend;
  logic [NUM_AREAS-1:0]             stat_hit, en_hit, stat_we, en_we;
  logic                             glob_hit;

  always_comb begin
    ev_all[AREA_LINK]  = ev_link;
    ev_all[AREA_RX]    = ev_rx;
    ev_all[AREA_TX]    = ev_tx;
    ev_all[AREA_ASYNC] = ev_async;
  end

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr_en    (bus_wr_en),
    .stat_hit (stat_hit),
    .en_hit   (en_hit),
    .glob_hit (glob_hit),
    .stat_we  (stat_we),
    .en_we    (en_we)
  );

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    irq_area_reg #(.STAT_W(STAT_W)) u_area (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev_all[g]),
      .stat_we (stat_we[g]),
      .en_we   (en_we[g]),
      .wdata   (bus_wdata[STAT_W-1:0]),
      .stat    (stat_all[g]),
      .en      (en_all[g]),
      .pending (pend[g])
    );
  end

  assign irq_summary = pend;
  assign irq_n       = ~|pend;

  irq_read_mux #(.STAT_W(STAT_W), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_rd_en),
    .stat_hit (stat_hit),
    .en_hit   (en_hit),
    .glob_hit (glob_hit),
    .stat_all (stat_all),
    .en_all   (en_all),
    .summary  (pend),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  // R7: the line is low exactly when some enabled status bit is set
  p_irq_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n) == (|(stat_all & en_all)));

  // R1: coming out of reset the line is idle
  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> irq_n);
endmodule

// File: tb/irq_hier_agg_tb.sv
module irq_hier_agg_tb;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] ev_link = '0, ev_rx = '0, ev_tx = '0, ev_async = '0;
  logic          bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [3:0]    irq_summary;
  logic          irq_n;

  int n_cmp = 0, n_mis = 0;
  bit done = 1'b0;
  logic [SW-1:0] m_stat [4];
  logic [SW-1:0] m_en [4];

  always #10 clk = ~clk;

  irq_hier_agg #(.STAT_W(SW), .ADDR_W(12), .DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_link(ev_link), .ev_rx(ev_rx), .ev_tx(ev_tx),
    .ev_async(ev_async), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_summary(irq_summary), .irq_n(irq_n)
  );

  function automatic logic [11:0] st_addr(input int a);
    case (a)
      0: return 12'h008;
      1: return 12'h04C;
      2: return 12'h02C;
      default: return 12'h0A0;
    endcase
  endfunction

  function automatic logic [3:0] exp_sum();
    logic [3:0] s;
    for (int i = 0; i < 4; i++) s[i] = |(m_stat[i] & m_en[i]);
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ev(input int a, input logic [SW-1:0] v);
    case (a)
      0: ev_link = v;
      1: ev_rx = v;
      2: ev_tx = v;
      default: ev_async = v;
    endcase
  endtask

  task automatic wr(input logic [11:0] ad, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = ad; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] ad, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = ad;
    @(negedge clk);
    bus_rd_en = 1'b0;
    chk("R9 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic pulse(input int a, input logic [SW-1:0] v);
    @(negedge clk);
    set_ev(a, v);
    @(negedge clk);
    set_ev(a, '0);
    m_stat[a] = m_stat[a] | v;
  endtask

  task automatic ack(input int a, input logic [SW-1:0] m);
    wr(st_addr(a), 32'(m));
    m_stat[a] = m_stat[a] & ~m;
  endtask

  task automatic check_line(input string req);
    chk({req, " summary"}, 32'(irq_summary), 32'(exp_sum()));
    chk({req, " irq_n"}, {31'd0, irq_n}, {31'd0, ~|exp_sum()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin m_stat[i] = '0; m_en[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_line("R1");
    for (int a = 0; a < 4; a++) begin
      rd(st_addr(a), d);           chk("R1 status", d, 32'd0);
      rd(st_addr(a) + 12'd4, d);   chk("R1 enable", d, 32'd0);
    end
    @(negedge clk);
    chk("R9 idle rvalid", {31'd0, bus_rvalid}, 32'd0);

    // sweep: every area, every enable mask, every event pattern
    for (int a = 0; a < 4; a++) begin
      for (int e = 0; e < 16; e++) begin
        wr(st_addr(a) + 12'd4, 32'(e));
        m_en[a] = SW'(e);
        rd(st_addr(a) + 12'd4, d); chk("R5 enable readback", d, 32'(e));
        for (int p = 1; p < 16; p++) begin
          pulse(a, SW'(p));
          check_line("R6/R7 after pulse");
          rd(st_addr(a), d);        chk("R2 latched status", d, 32'(m_stat[a]));
          rd(12'h018, d);           chk("R6 global word", d, 32'(exp_sum()));
          ack(a, SW'(e ^ 5));
          rd(st_addr(a), d);        chk("R3 partial ack", d, 32'(m_stat[a]));
          check_line("R8 after partial ack");
          ack(a, '1);
          check_line("R8 after full ack");
        end
      end
      wr(st_addr(a) + 12'd4, 32'd0);
      m_en[a] = '0;
    end

    // R2 latch with enable off, line stays high
    pulse(0, 4'b1010);
    chk("R2 masked irq_n", {31'd0, irq_n}, 32'd1);
    rd(st_addr(0), d); chk("R2 masked latch", d, 32'hA);

    // R4 event and clear in the same cycle
    pulse(0, 4'b0011);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = st_addr(0); bus_wdata = 32'h3; ev_link = 4'b0001;
    @(negedge clk);
    bus_wr_en = 1'b0; ev_link = '0;
    m_stat[0] = 4'b1001;
    rd(st_addr(0), d); chk("R4 event wins", d, 32'h9);
    ack(0, '1);

    // R8 writes to the summary address are ignored, multiple areas
    wr(st_addr(1) + 12'd4, 32'hF); m_en[1] = 4'hF;
    wr(st_addr(3) + 12'd4, 32'h2); m_en[3] = 4'h2;
    pulse(1, 4'h4);
    pulse(3, 4'h2);
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h018, d); chk("R8 global write ignored", d, 32'ha);
    check_line("R6 two areas");
    ack(1, 4'h4);
    rd(12'h018, d); chk("R8 self clear rx", d, 32'h8);
    ack(3, 4'h2);
    check_line("R7 all acked");

    // R10 upper bits
    wr(st_addr(2) + 12'd4, 32'hFFFF_FFFF); m_en[2] = 4'hF;
    rd(st_addr(2) + 12'd4, d); chk("R10 enable width", d, 32'hF);
    pulse(2, 4'hF);
    rd(st_addr(2), d); chk("R10 status width", d, 32'hF);
    ack(2, '1);

    // R9 unmapped addresses read zero
    rd(12'h010, d); chk("R9 unmapped 010", d, 32'd0);
    rd(12'h0FC, d); chk("R9 unmapped 0FC", d, 32'd0);
    rd(12'h014, d); chk("R9 unmapped 014", d, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule